// File: doc/BRIEF.md
# Shadowed Four-Channel PWM Generator

This block produces a bank of pulse-width modulated outputs from a slow time base. The 1 MHz time base arrives as a one-clock enable pulse, `tick_1m`. Each channel has three word registers on a simple write/read port:

- a 16-bit period,
- a 16-bit duty,
- a control word that holds a power-of-two prescaler select and an output polarity flag.

Each channel counts prescaled ticks. Its output sits at the active level while the count is below the duty, and at the inactive level for the rest of the period.

Software writes duty and control first. These land in shadow storage and do nothing to the running waveform. A write to the period register then arms the channel. At the end of the running period, all three shadowed values move into the active set in one step, so the waveform never shows a mix of old and new settings. A channel that is not running picks up an armed setting at the next tick. Arming a period of zero is a graceful stop: the running period completes, and the output then stays low whatever the polarity.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero, every channel is stopped and every output bit is low.
- R2: Register addresses are byte addresses, with channel ch in 0..3:
  - period at 0x400+4*ch,
  - duty at 0x420+4*ch,
  - control at 0x440+4*ch.

  Period and duty keep data bits [15:0]. Control keeps the prescaler select in bits [1:0] and polarity in bit 5, and its other bits read zero. Read data shows, one clock after the address, the last value written. A misaligned or unmapped address reads zero.
- R3: On a stopped channel, writing a nonzero period starts the channel at the next tick with the shadowed duty and control. The count is 0 in the first tick interval.
- R4: While running, the count steps from 0 to period-1 and wraps. The output is active while count < duty.
- R5: A prescaler select of s makes each count last 2^s ticks (s = 0..3).
- R6: A duty of 0 gives a constant inactive output. A duty of at least the period gives a constant active output.
- R7: With control bit 5 set, the output is inverted (active level low).
- R8: Duty and control writes that are not followed by a period write leave the running waveform unchanged.
- R9: After a period write, the channel runs out the current period. It then switches period, duty, prescaler and polarity together at the boundary, with count 0 in the first new interval.
- R10: A period of 0 stops the channel after the running period. A stopped channel outputs low regardless of polarity.
- R11: Writes to one channel do not change the waveform of any other channel.
- R12: Each output is registered. It changes only in the second clock after a tick, never in the clock of the tick itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1m | input | 1 | One-clock enable pulse at the 1 MHz time base |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| pwm_out | output | 4 | PWM outputs, one bit per channel |

## Verification
Every cycle, the assertions check four things:
- outputs are low and read data is zero straight after reset,
- outputs move only two clocks after a tick,
- a period or duty register reads back what was last written to it,
- unmapped addresses read zero.

Only the directed scenarios can show the waveform itself:
- the duty/period shape under each prescaler,
- the polarity inversion,
- the deferred switch at the period boundary,
- the graceful stop,
- the independence of channels.

Each of these is compared, sample by sample, against patterns computed from the requirements.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Register kind, decoded from address bits [7:5]
  typedef enum logic [2:0] {
    KIND_PERIOD = 3'd0,
    KIND_DUTY   = 3'd1,
    KIND_CTRL   = 3'd2
  } reg_kind_e;

  localparam int BANK_PAGE    = 4;  // address >> 8 of the register bank
  localparam int CTRL_POL_BIT = 5;  // polarity flag in the control word
  localparam int CH_SEL_W     = 3;  // channel field, address bits [4:2]
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 2,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic [NCH-1:0][CNT_W-1:0]   sh_period,
  output logic [NCH-1:0][CNT_W-1:0]   sh_duty,
  output logic [NCH-1:0][DIV_W-1:0]   sh_div,
  output logic [NCH-1:0]              sh_pol,
  output logic [NCH-1:0]              per_wr
);
  logic                page_hit;
  logic                align_ok;
  logic                chan_ok;
  logic                hit;
  logic [CH_SEL_W-1:0] chan;
  reg_kind_e           kind;
  logic [DATA_W-1:0]   rd_mux;
  logic                unused_wbits;

  assign page_hit     = (addr >> 8) == ADDR_W'(BANK_PAGE);
  assign align_ok     = (addr[1:0] == 2'b00);
  assign chan         = addr[4:2];
  assign chan_ok      = int'(chan) < NCH;
  assign kind         = reg_kind_e'(addr[7:5]);
  assign hit          = page_hit && align_ok && chan_ok;
  assign unused_wbits = ^wdata;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_shadow
    logic             sel;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] duty_q;
    logic [DIV_W-1:0] div_q;
    logic             pol_q;

    assign sel = hit && (int'(chan) == ch);

    always_ff @(posedge clk) begin
      if (rst) begin
        per_q  <= '0;
        duty_q <= '0;
        div_q  <= '0;
        pol_q  <= 1'b0;
      end else if (we && sel) begin
        case (kind)
          KIND_PERIOD: per_q  <= wdata[CNT_W-1:0];
          KIND_DUTY:   duty_q <= wdata[CNT_W-1:0];
          KIND_CTRL: begin
            div_q <= wdata[DIV_W-1:0];
            pol_q <= wdata[CTRL_POL_BIT];
          end
          default: ;
        endcase
      end
    end

    assign sh_period[ch] = per_q;
    assign sh_duty[ch]   = duty_q;
    assign sh_div[ch]    = div_q;
    assign sh_pol[ch]    = pol_q;
    assign per_wr[ch]    = we && sel && (kind == KIND_PERIOD);
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      for (int c = 0; c < NCH; c++) begin
        if (int'(chan) == c) begin
          case (kind)
            KIND_PERIOD: rd_mux[CNT_W-1:0] = sh_period[c];
            KIND_DUTY:   rd_mux[CNT_W-1:0] = sh_duty[c];
            KIND_CTRL: begin
              rd_mux[DIV_W-1:0]    = sh_div[c];
              rd_mux[CTRL_POL_BIT] = sh_pol[c];
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             arm_set,
  input  logic [CNT_W-1:0] sh_period,
  input  logic [CNT_W-1:0] sh_duty,
  input  logic [DIV_W-1:0] sh_div,
  input  logic             sh_pol,
  output logic             pwm_q
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic             armed;
  logic             running;
  logic [CNT_W-1:0] act_period;
  logic [CNT_W-1:0] act_duty;
  logic [DIV_W-1:0] act_div;
  logic             act_pol;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [PRE_W:0]   pre_lim;
  logic             pre_last;
  logic             period_end;
  logic             load;

  assign pre_lim    = ((PRE_W+1)'(1) << act_div) - (PRE_W+1)'(1);
  assign pre_last   = ({1'b0, pre} == pre_lim);
  assign period_end = tick && running && pre_last && (cnt == act_period - CNT_W'(1));
  assign load       = tick && armed && (!running || period_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      running    <= 1'b0;
      act_period <= '0;
      act_duty   <= '0;
      act_div    <= '0;
      act_pol    <= 1'b0;
      cnt        <= '0;
      pre        <= '0;
    end else begin
      if (arm_set)   armed <= 1'b1;
      else if (load) armed <= 1'b0;

      if (load) begin
        act_period <= sh_period;
        act_duty   <= sh_duty;
        act_div    <= sh_div;
        act_pol    <= sh_pol;
        running    <= (sh_period != '0);
        cnt        <= '0;
        pre        <= '0;
      end else if (tick && running) begin
        if (pre_last) begin
          pre <= '0;
          cnt <= period_end ? '0 : cnt + CNT_W'(1);
        end else begin
          pre <= pre + PRE_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= running && ((cnt < act_duty) ^ act_pol);
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 2,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1m,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0][CNT_W-1:0] sh_period;
  logic [NCH-1:0][CNT_W-1:0] sh_duty;
  logic [NCH-1:0][DIV_W-1:0] sh_div;
  logic [NCH-1:0]            sh_pol;
  logic [NCH-1:0]            per_wr;

  pwm_regfile #(
    .NCH(NCH), .CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .sh_period(sh_period), .sh_duty(sh_duty),
    .sh_div(sh_div), .sh_pol(sh_pol), .per_wr(per_wr)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pwm_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chan (
      .clk(clk), .rst(rst), .tick(tick_1m), .arm_set(per_wr[ch]),
      .sh_period(sh_period[ch]), .sh_duty(sh_duty[ch]),
      .sh_div(sh_div[ch]), .sh_pol(sh_pol[ch]), .pwm_q(pwm_out[ch])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_1m,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NCH-1:0]    pwm_out
);
  function automatic logic is_mapped(logic [ADDR_W-1:0] a, int kinds);
    return ((a >> 8) == ADDR_W'(4)) && (a[1:0] == 2'b00) &&
           (int'(a[4:2]) < NCH) && (int'(a[7:5]) < kinds);
  endfunction

  // R1: straight after reset, outputs and read data are zero
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pwm_out == '0) && (reg_rdata == '0));

  // R12: an output moves only two clocks after a tick
  assert_change_after_tick_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (pwm_out != $past(pwm_out))) |-> $past(tick_1m, 2));

  // R2: a period or duty register reads back its last write
  assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_we, 2) && !$past(reg_we) && !$past(rst) && !$past(rst, 2) &&
     ($past(reg_addr, 2) == $past(reg_addr)) && is_mapped($past(reg_addr), 2))
    |-> (reg_rdata[CNT_W-1:0] == $past(reg_wdata[CNT_W-1:0], 2)) &&
        (reg_rdata[DATA_W-1:CNT_W] == '0));

  // R2: unmapped or misaligned addresses read zero
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !is_mapped($past(reg_addr), 3)) |-> (reg_rdata == '0));
endmodule

bind pwm_bank pwm_bank_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .tick_1m(tick_1m), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .pwm_out(pwm_out)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1m = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_out;
  logic [3:0]  mid_q;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  pwm_bank u_dut (
    .clk(clk), .rst(rst), .tick_1m(tick_1m), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [11:0] a_per(int ch);  return 12'(12'h400 + 4*ch); endfunction
  function automatic logic [11:0] a_duty(int ch); return 12'(12'h420 + 4*ch); endfunction
  function automatic logic [11:0] a_ctrl(int ch); return 12'(12'h440 + 4*ch); endfunction

  // Level expected at tick sample i of a run with period p, duty d, select s
  function automatic logic exp_lvl(int i, int p, int d, int s, bit pol);
    int c = (i >> s) % p;
    return (c < d) ^ pol;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; reg_we = 1'b0; tick_1m = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  // One tick; mid_q is taken after the state edge, the sample after the output edge
  task automatic do_tick();
    @(negedge clk); tick_1m = 1'b1;
    @(negedge clk); tick_1m = 1'b0; mid_q = pwm_out;
    @(negedge clk);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    chk("R1 outputs", 32'(pwm_out), 0);
    for (int ch = 0; ch < 4; ch++) begin
      rd(a_per(ch), d);  chk("R1 period", d, 0);
      rd(a_duty(ch), d); chk("R1 duty", d, 0);
      rd(a_ctrl(ch), d); chk("R1 ctrl", d, 0);
    end
    wr(a_ctrl(2), 32'hFFFF_FFFF); rd(a_ctrl(2), d); chk("R2 ctrl bits", d, 32'h23);
    wr(a_duty(1), 32'h0001_2345); rd(a_duty(1), d); chk("R2 duty", d, 32'h2345);
    wr(a_per(3), 32'h0000_ABCD);  rd(a_per(3), d);  chk("R2 period", d, 32'hABCD);
    rd(12'h460, d); chk("R2 unmapped", d, 0);
    rd(12'h402, d); chk("R2 misaligned", d, 0);
    rd(12'h41C, d); chk("R2 channel out of range", d, 0);
  endtask

  task automatic t_basic();
    do_reset();
    wr(a_duty(0), 3); wr(a_ctrl(0), 0); wr(a_per(0), 5);
    for (int i = 0; i < 15; i++) begin
      do_tick();
      if (i == 3) chk("R12 no change in tick clock", 32'(mid_q[0]), 1);
      chk(i == 0 ? "R3 start" : "R4 shape", 32'(pwm_out[0]), 32'(exp_lvl(i, 5, 3, 0, 0)));
      chk("R11 idle channels", 32'(pwm_out[3:1]), 0);
    end
  endtask

  task automatic t_div();
    do_reset();
    wr(a_ctrl(1), 2); wr(a_duty(1), 1); wr(a_per(1), 3);
    for (int i = 0; i < 24; i++) begin
      do_tick();
      chk("R5 prescale by 4", 32'(pwm_out[1]), 32'(exp_lvl(i, 3, 1, 2, 0)));
    end
  endtask

  task automatic t_extremes();
    do_reset();
    wr(a_duty(2), 0); wr(a_per(2), 4);
    wr(a_duty(3), 9); wr(a_per(3), 4);
    for (int i = 0; i < 8; i++) begin
      do_tick();
      chk("R6 duty zero", 32'(pwm_out[2]), 0);
      chk("R6 duty over period", 32'(pwm_out[3]), 1);
    end
  endtask

  task automatic t_pol();
    do_reset();
    wr(a_ctrl(0), 32'h20); wr(a_duty(0), 1);
    do_tick();
    chk("R10 stopped inverted channel low", 32'(pwm_out[0]), 0);
    wr(a_per(0), 4);
    for (int i = 0; i < 8; i++) begin
      do_tick();
      chk("R7 inverted", 32'(pwm_out[0]), 32'(exp_lvl(i, 4, 1, 0, 1)));
    end
  endtask

  task automatic t_shadow();
    do_reset();
    wr(a_duty(0), 2); wr(a_per(0), 6);
    for (int i = 0; i < 30; i++) begin
      do_tick();
      if (i < 18)
        chk("R8 old settings hold", 32'(pwm_out[0]), 32'(exp_lvl(i, 6, 2, 0, 0)));
      else
        chk("R9 new settings at boundary", 32'(pwm_out[0]), 32'(exp_lvl(i - 18, 4, 3, 0, 1)));
      if (i == 1) begin wr(a_duty(0), 3); wr(a_ctrl(0), 32'h20); end
      if (i == 14) wr(a_per(0), 4);
    end
  endtask

  task automatic t_stop();
    logic [31:0] d;
    do_reset();
    wr(a_ctrl(1), 32'h20); wr(a_duty(1), 2); wr(a_per(1), 4);
    for (int i = 0; i < 16; i++) begin
      do_tick();
      if (i < 8)
        chk("R10 period runs out", 32'(pwm_out[1]), 32'(exp_lvl(i, 4, 2, 0, 1)));
      else
        chk("R10 held low", 32'(pwm_out[1]), 0);
      if (i == 5) wr(a_per(1), 0);
    end
    rd(a_per(1), d); chk("R2 period zero", d, 0);
  endtask

  task automatic t_iso();
    do_reset();
    wr(a_duty(0), 2); wr(a_per(0), 5);
    for (int i = 0; i < 20; i++) begin
      do_tick();
      chk("R11 channel 0 undisturbed", 32'(pwm_out[0]), 32'(exp_lvl(i, 5, 2, 0, 0)));
      if (i >= 5)
        chk("R11 channel 1 own run", 32'(pwm_out[1]), 32'(exp_lvl(i - 5, 3, 1, 1, 0)));
      if (i == 4) begin wr(a_duty(1), 1); wr(a_ctrl(1), 1); wr(a_per(1), 3); end
      if (i == 9) begin wr(a_duty(2), 7); wr(a_per(2), 7); end
    end
  endtask

  initial begin
    t_regs();
    t_basic();
    t_div();
    t_extremes();
    t_pol();
    t_shadow();
    t_stop();
    t_iso();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule